// File: doc/BRIEF.md
# Region-Configured External Bus Controller

This block sits between a 32-bit core request port and an external memory bus that has separate address and data lines. The top four address bits pick one of sixteen regions. Each region has an 8-bit configuration word that sets four things: the external data bus width, the number of internal wait states, whether bursts are allowed, and the byte order. A core request carries an address, a size of 1, 2 or 4 bytes, a direction and write data.

Requests go into a three-entry queue, so the core can keep posting while the bus is busy. One request at a time leaves the queue. The request is split into as many external beats as its alignment and the region width require. Write bytes are steered onto the correct lanes, and read bytes are collected into a single word. The core sees a one-cycle completion pulse once every beat of the request has finished.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Address bits [31:28] of a request select its region. The region's word in `cfg_table_i` sits at bits [8r+7:8r] with this layout: [1:0] width code, [5:2] wait count, [6] burst enable, [7] big-endian. That word governs every beat of the request.
- R2: Width code 0 gives an 8-bit bus, code 1 a 16-bit bus, and codes 2 and 3 a 32-bit bus, so W is 1, 2 or 4 bytes. `bus_addr_o` is always a multiple of W. The byte at external address A travels on lane (A mod W), which is bits [8L+7:8L]. Lanes at or above W are never enabled.
- R3: Up to three requests wait in the queue. `req_ready_o` is low while three are waiting. Requests are served and completed in the order they were accepted.
- R4: A beat that starts a new access takes 1 + wait-count cycles with `bus_cyc_o` high. `bus_dstb_o` is high only in its last cycle.
- R5: In a region with burst enabled, a beat that follows a beat of the same request takes one cycle. The exception is a beat whose address has bits [3:0] equal to zero; it starts a new access. `bus_as_o` is high in the first cycle of every beat that starts a new access, and in no other cycle.
- R6: Size code 0, 1 or 2 (3 acts as 2) asks for n = 1, 2 or 4 bytes starting at any byte address. Each beat moves min(W − (A mod W), bytes remaining) bytes. Exactly the n bytes at addresses base..base+n−1 are transferred.
- R7: With the endian bit at 0, value byte k (bits [8k+7:8k]) maps to address base+k. With the bit at 1, address base+k maps to value byte n−1−k. Read results occupy the low n bytes, and the upper bytes are zero.
- R8: Each request ends with a single-cycle `rsp_valid_o`. It comes in the cycle after its last data strobe. `rsp_rdata_o` holds the assembled read word, or zero for a write.
- R9: `bus_addr_o` is held constant from the first cycle of a beat to its data strobe. `bus_dstb_o` and `bus_as_o` are only high while `bus_cyc_o` is high.
- R10: After reset, `req_ready_o` is high and `bus_cyc_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_table_i | input | 128 | Sixteen 8-bit region configuration words |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Queue can accept a request |
| req_we_i | input | 1 | Request is a write |
| req_addr_i | input | 32 | Request byte address |
| req_size_i | input | 2 | Size code: 1, 2 or 4 bytes |
| req_wdata_i | input | 32 | Write value, low n bytes used |
| rsp_valid_o | output | 1 | Request complete pulse |
| rsp_rdata_o | output | 32 | Assembled read value |
| bus_cyc_o | output | 1 | External beat in progress |
| bus_as_o | output | 1 | First cycle of a new access |
| bus_we_o | output | 1 | Beat direction |
| bus_addr_o | output | 32 | Width-aligned beat address |
| bus_be_o | output | 4 | Enabled byte lanes |
| bus_wdata_o | output | 32 | Write lanes |
| bus_rdata_i | input | 32 | Read lanes |
| bus_dstb_o | output | 1 | Data transferred this cycle |

## Verification
The properties assume two things about the inputs. First, `cfg_table_i` does not change while any request is queued or in flight. Second, the external side returns read lanes in the same cycle as the data strobe. The bench keeps to both. It writes the region table once, before reset is released. Its memory model derives every read byte combinationally from the presented address. The bench also never issues a request that spans two regions, because each address is a small offset from a region base.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int NBYTES  = DATA_W / 8;
  localparam int CFG_W   = 8;
  localparam int BURST_SPAN_LSB = 4;  // bursts break at 16-byte boundaries

  typedef struct packed {
    logic              big_end;
    logic              burst;
    logic [3:0]        wait_n;
    logic [1:0]        width;
  } region_cfg_t;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [DATA_W-1:0] wdata;
  } req_t;

  typedef enum logic {ST_IDLE, ST_XFER} eng_st_e;
endpackage

// File: rtl/ebc_req_fifo.sv
module ebc_req_fifo #(
  parameter int  DEPTH = 3,
  parameter type T     = logic
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  T     data_i,
  output logic full_o,
  input  logic pop_i,
  output logic empty_o,
  output T     head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  T              mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/ebc_region_table.sv
module ebc_region_table
  import ebc_pkg::*;
#(
  parameter int NREG  = 16,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic [NREG*CFG_W-1:0] cfg_flat_i,
  input  logic [SEL_W-1:0]      sel_i,
  output region_cfg_t           cfg_o
);
  region_cfg_t tbl [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign tbl[r] = region_cfg_t'(cfg_flat_i[r*CFG_W +: CFG_W]);
  end

  assign cfg_o = tbl[sel_i];
endmodule

// File: rtl/ebc_beat_engine.sv
module ebc_beat_engine
  import ebc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  req_t              head_i,
  input  region_cfg_t       cfg_i,
  output logic              pop_o,
  output logic              bus_cyc_o,
  output logic              bus_as_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [NBYTES-1:0] bus_be_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_dstb_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  eng_st_e           st_q;
  req_t              cur_q;
  region_cfg_t       cfg_q;
  logic [2:0]        off_q;
  logic [3:0]        wcnt_q;
  logic              as_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic [2:0]        n_bytes, w_bytes, mask, lane0, room, rem, nb;
  logic [ADDR_W-1:0] a_cur, nxt_addr;
  logic              last_beat, cont, xfer;
  logic [2:0]        k, lane, idx;
  logic [NBYTES-1:0] be;
  logic [DATA_W-1:0] wd, rd_next;

  always_comb begin
    n_bytes   = (cur_q.size[1]) ? 3'd4 : (cur_q.size[0] ? 3'd2 : 3'd1);
    w_bytes   = (cfg_q.width[1]) ? 3'd4 : (cfg_q.width[0] ? 3'd2 : 3'd1);
    mask      = w_bytes - 3'd1;
    a_cur     = cur_q.addr + ADDR_W'(off_q);
    lane0     = {1'b0, a_cur[1:0]} & mask;
    room      = w_bytes - lane0;
    rem       = n_bytes - off_q;
    nb        = (room < rem) ? room : rem;
    last_beat = ((off_q + nb) == n_bytes);
    nxt_addr  = a_cur + ADDR_W'(nb);
    cont      = cfg_q.burst && (nxt_addr[BURST_SPAN_LSB-1:0] != '0);
  end

  // byte steering between value bytes and bus lanes
  always_comb begin
    be      = '0;
    wd      = '0;
    rd_next = rdata_q;
    k       = '0;
    lane    = '0;
    idx     = '0;
    for (int j = 0; j < NBYTES; j++) begin
      if (3'(j) < nb) begin
        k    = off_q + 3'(j);
        lane = lane0 + 3'(j);
        idx  = cfg_q.big_end ? (n_bytes - 3'd1 - k) : k;
        be[lane[1:0]] = 1'b1;
        wd[{lane[1:0], 3'b000} +: 8]      = cur_q.wdata[{idx[1:0], 3'b000} +: 8];
        rd_next[{idx[1:0], 3'b000} +: 8]  = bus_rdata_i[{lane[1:0], 3'b000} +: 8];
      end
    end
  end

  assign xfer        = (st_q == ST_XFER);
  assign pop_o       = (st_q == ST_IDLE) && head_valid_i;
  assign bus_cyc_o   = xfer;
  assign bus_as_o    = xfer && as_q;
  assign bus_dstb_o  = xfer && (wcnt_q == '0);
  assign bus_we_o    = xfer && cur_q.we;
  assign bus_addr_o  = xfer ? {a_cur[ADDR_W-1:2], a_cur[1:0] & ~mask[1:0]} : '0;
  assign bus_be_o    = xfer ? be : '0;
  assign bus_wdata_o = (xfer && cur_q.we) ? wd : '0;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      cfg_q       <= '0;
      off_q       <= '0;
      wcnt_q      <= '0;
      as_q        <= 1'b0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (head_valid_i) begin
            cur_q   <= head_i;
            cfg_q   <= cfg_i;
            off_q   <= '0;
            wcnt_q  <= cfg_i.wait_n;
            as_q    <= 1'b1;
            rdata_q <= '0;
            st_q    <= ST_XFER;
          end
        end
        default: begin
          if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - 4'd1;
            as_q   <= 1'b0;
          end else begin
            off_q <= off_q + nb;
            if (!cur_q.we) rdata_q <= rd_next;
            if (last_beat) begin
              rsp_valid_q <= 1'b1;
              rsp_rdata_q <= cur_q.we ? '0 : rd_next;
              as_q        <= 1'b0;
              st_q        <= ST_IDLE;
            end else begin
              wcnt_q <= cont ? 4'd0 : cfg_q.wait_n;
              as_q   <= !cont;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int QDEPTH = 3,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NREG*CFG_W-1:0] cfg_table_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [1:0]            req_size_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_rdata_o,
  output logic                  bus_cyc_o,
  output logic                  bus_as_o,
  output logic                  bus_we_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic [NBYTES-1:0]     bus_be_o,
  output logic [DATA_W-1:0]     bus_wdata_o,
  input  logic [DATA_W-1:0]     bus_rdata_i,
  output logic                  bus_dstb_o
);
  req_t        q_in, q_head;
  logic        q_full, q_empty, q_pop, q_push;
  region_cfg_t head_cfg;

  assign q_in        = '{we: req_we_i, addr: req_addr_i, size: req_size_i, wdata: req_wdata_i};
  assign req_ready_o = !q_full;
  assign q_push      = req_valid_i && req_ready_o;

  ebc_req_fifo #(.DEPTH(QDEPTH), .T(req_t)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .data_i  (q_in),
    .full_o  (q_full),
    .pop_i   (q_pop),
    .empty_o (q_empty),
    .head_o  (q_head)
  );

  ebc_region_table #(.NREG(NREG)) u_table (
    .cfg_flat_i (cfg_table_i),
    .sel_i      (q_head.addr[ADDR_W-1 -: SEL_W]),
    .cfg_o      (head_cfg)
  );

  ebc_beat_engine u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_valid_i (!q_empty),
    .head_i       (q_head),
    .cfg_i        (head_cfg),
    .pop_o        (q_pop),
    .bus_cyc_o    (bus_cyc_o),
    .bus_as_o     (bus_as_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_be_o     (bus_be_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_dstb_o   (bus_dstb_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
  parameter int QDEPTH = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        q_pop,
  input logic        rsp_valid_o,
  input logic        bus_cyc_o,
  input logic        bus_as_o,
  input logic        bus_dstb_o,
  input logic [31:0] bus_addr_o,
  input logic [3:0]  bus_be_o
);
  localparam int CW = $clog2(QDEPTH + 2);
  logic [CW-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else held_q <= held_q + CW'(req_valid_i && req_ready_o) - CW'(q_pop);
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q <= CW'(QDEPTH));
  p_full_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q == CW'(QDEPTH)) |-> !req_ready_o);
  p_room_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q < CW'(QDEPTH)) |-> req_ready_o);
  p_dstb_in_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dstb_o |-> bus_cyc_o);
  p_as_in_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_as_o |-> bus_cyc_o);
  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !bus_dstb_o) |=> (bus_cyc_o && $stable(bus_addr_o)));
  p_lanes_used_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dstb_o |-> (bus_be_o != 4'b0));
  p_rsp_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_rsp_after_dstb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(bus_dstb_o));
endmodule

bind ext_bus_ctrl ebc_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .q_pop       (q_pop),
  .rsp_valid_o (rsp_valid_o),
  .bus_cyc_o   (bus_cyc_o),
  .bus_as_o    (bus_as_o),
  .bus_dstb_o  (bus_dstb_o),
  .bus_addr_o  (bus_addr_o),
  .bus_be_o    (bus_be_o)
);

// File: tb/tb_ext_bus_ctrl.sv
module tb_ext_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [127:0] cfg_table;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bus_cyc, bus_as, bus_we, bus_dstb;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_table_i(cfg_table),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_cyc_o(bus_cyc), .bus_as_o(bus_as), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_dstb_o(bus_dstb)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[31:28], a[11:8]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cfg_of(input int r);
    logic [1:0] w;
    logic [3:0] ws;
    if (r == 15) return {1'b0, 1'b0, 4'd15, 2'd0};
    w  = 2'(r % 4);
    ws = 4'((r * 5) % 7);
    return {1'(r[2] ^ r[0]), 1'(r[1]), ws, w};
  endfunction

  always_comb begin
    for (int l = 0; l < 4; l++) bus_rdata[l*8 +: 8] = mem_byte(bus_addr + 32'(l));
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // bus monitor state
  int          mon_cyc, mon_as, mon_beats, mon_bytes, mon_bad;
  logic [31:0] mon_base;
  int          mon_n, mon_w;
  logic [7:0]  exp_wb [4];

  always @(negedge clk) begin
    if (bus_cyc) begin
      mon_cyc++;
      if (bus_as) mon_as++;
      if (bus_dstb) begin
        mon_beats++;
        if ((bus_addr % 32'(mon_w)) != 0) mon_bad++;
        for (int l = 0; l < 4; l++) begin
          if (bus_be[l]) begin
            logic [31:0] a, kk;
            a  = bus_addr + 32'(l);
            kk = a - mon_base;
            mon_bytes++;
            if (l >= mon_w || kk >= 32'(mon_n)) mon_bad++;
            else if (bus_we && bus_wdata[l*8 +: 8] != exp_wb[kk[1:0]]) mon_bad++;
          end
        end
      end
    end
  end

  task automatic do_req(input bit we, input logic [31:0] addr, input logic [1:0] sz, input logic [31:0] wd);
    int r, w, ws, n, off, nb, l0, e_cyc, e_as, e_beats;
    bit bu, big, first, newacc;
    logic [7:0]  c;
    logic [31:0] e_rd, a;
    r   = int'(addr[31:28]);
    c   = cfg_of(r);
    w   = (c[1:0] >= 2) ? 4 : (c[1:0] == 1 ? 2 : 1);
    ws  = int'(c[5:2]);
    bu  = c[6];
    big = c[7];
    n   = (sz >= 2) ? 4 : (sz == 1 ? 2 : 1);
    e_rd = '0;
    for (int k = 0; k < n; k++) begin
      int ix;
      ix = big ? n - 1 - k : k;
      e_rd[ix*8 +: 8] = mem_byte(addr + 32'(k));
      exp_wb[k] = wd[ix*8 +: 8];
    end
    off = 0; first = 1; e_cyc = 0; e_as = 0; e_beats = 0;
    while (off < n) begin
      a  = addr + 32'(off);
      l0 = int'(a % 32'(w));
      nb = (w - l0 < n - off) ? w - l0 : n - off;
      newacc = first || !bu || (a[3:0] == 4'h0);
      e_cyc += newacc ? 1 + ws : 1;
      if (newacc) e_as++;
      e_beats++;
      off += nb;
      first = 0;
    end
    @(negedge clk);
    mon_cyc = 0; mon_as = 0; mon_beats = 0; mon_bytes = 0; mon_bad = 0;
    mon_base = addr; mon_n = n; mon_w = w;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    if (we) chk(rsp_rdata == 32'h0, "R8 write rdata zero", rsp_rdata, 32'h0);
    else    chk(rsp_rdata == e_rd, "R7 read assembly", rsp_rdata, e_rd);
    chk(mon_beats == e_beats, "R6 beat count", 32'(mon_beats), 32'(e_beats));
    chk(mon_bytes == n, "R6 bytes moved", 32'(mon_bytes), 32'(n));
    chk(mon_cyc == e_cyc, "R4 bus cycles", 32'(mon_cyc), 32'(e_cyc));
    chk(mon_as == e_as, "R5 access starts", 32'(mon_as), 32'(e_as));
    chk(mon_bad == 0, "R2 lane/align/data R1", 32'(mon_bad), 32'h0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single pulse", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int offs [7] = '{0, 1, 2, 3, 13, 14, 15};
    bit saw_full;
    logic [31:0] q_exp [5];
    for (int r = 0; r < 16; r++) cfg_table[r*8 +: 8] = cfg_of(r);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
    chk(bus_cyc == 1'b0, "R10 bus idle", 32'(bus_cyc), 32'h0);
    chk(rsp_valid == 1'b0, "R10 no response", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep regions, offsets, sizes, directions (R1 R2 R4 R5 R6 R7 R8)
    for (int r = 0; r < 16; r++)
      for (int o = 0; o < 7; o++)
        for (int s = 0; s < 3; s++)
          for (int d = 0; d < 2; d++)
            do_req(d[0], {4'(r), 20'h0, 8'h30} + 32'(offs[o]), 2'(s),
                   32'hA5C3_1E77 ^ (32'(r * 97 + o * 13 + s * 5 + d) * 32'h0103_0507));

    // queue fill and ordering on the slow region (R3)
    saw_full = 0;
    for (int i = 0; i < 5; i++)
      for (int k = 0; k < 4; k++)
        q_exp[i][k*8 +: 8] = mem_byte(32'hF000_0040 + 32'(i * 4 + k));
    fork
      begin
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          req_valid = 1'b1; req_we = 1'b0; req_size = 2'd2;
          req_addr = 32'hF000_0040 + 32'(i * 4);
          while (!req_ready) begin saw_full = 1; @(negedge clk); end
          @(negedge clk);
          req_valid = 1'b0;
        end
      end
      begin
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          while (!rsp_valid) @(negedge clk);
          chk(rsp_rdata == q_exp[i], "R3 completion order", rsp_rdata, q_exp[i]);
        end
      end
    join
    chk(saw_full == 1'b1, "R3 ready low when full", 32'(saw_full), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule